// File: doc/BRIEF.md
# 64-bit Countdown Timer

This block is a countdown timer peripheral that sits on a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. Software places a 64-bit start value in two 32-bit words. It then starts the counter with one control write that also picks the mode and whether the interrupt line is gated open. While the counter runs, the live 64-bit count can be read as two words at any time.

Each time the count is found at zero, the block raises a sticky expiry flag. In free-running mode the counter then restarts from the start value, so a start value of N-1 gives one expiry every N cycles. In one-shot mode it parks at zero until software starts it again. The interrupt output is the expiry flag gated by an unmask bit. Software clears the flag by writing a 1 to it.

The count is never latched on read. Software reads it high word, low word, high word, and keeps the low word only when both high-word reads agree.

Top module: `countdown_timer64`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Register map by byte offset: start value low word 0x00, start value high word 0x04, count low word 0x08, count high word 0x0C, control 0x10, expiry flag 0x18 (bit 0). The start words and the control bits [2:0] read back as written. Writes to 0x08 and 0x0C have no effect.
- R3: Control bit 0 is run. On the clock edge after a write takes run from 0 to 1, the count becomes the full 64-bit start value.
- R4: While run is 1, the count falls by one per cycle, with the borrow passing from the low word into the high word. The words at 0x08 and 0x0C show the live value. While run is 0, the count holds.
- R5: With control bit 1 at 0 (free-running), a count of zero sets the expiry flag on the next edge and reloads the start value. A start value L gives one expiry every L+1 cycles.
- R6: With control bit 1 at 1 (one-shot), a count of zero sets the expiry flag once. The count then stays at zero and raises no further expiry until run goes from 0 to 1 again.
- R7: The expiry flag is sticky. Writing 1 to bit 0 at 0x18 clears it. An expiry on the same edge as the clear wins, and the flag stays set.
- R8: `irq` equals the expiry flag AND control bit 2 (unmask). The flag is set even while the interrupt is masked, and unmasking later raises `irq` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, expiry flag gated by unmask |

## Verification
Two situations are hard to bring about from the ports. The first is a clear write that lands on the same edge as an expiry. The second is a borrow crossing from the low word into the high word while software reads the two words. The bench reaches the first by loading a start value of 0 in free-running mode, which makes an expiry occur on every edge, so any clear collides with one. It reaches the second by loading 0x1_00000002 and reading alternate words on consecutive cycles, so the step from 0x1_00000000 to 0x0_FFFFFFFF is seen live. Expiry timing is checked to the exact cycle: the bench counts edges from the enabling write and samples `irq` one cycle before and at the predicted expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    // Word indices (byte offset / 4) of the register map
    localparam int unsigned IDX_LOAD_LO = 0;
    localparam int unsigned IDX_LOAD_HI = 1;
    localparam int unsigned IDX_CNT_LO  = 2;
    localparam int unsigned IDX_CNT_HI  = 3;
    localparam int unsigned IDX_CTRL    = 4;
    localparam int unsigned IDX_FLAG    = 6;

    // Control field: bit 2 unmask, bit 1 one-shot, bit 0 run
    typedef struct packed {
        logic unmask;
        logic oneshot;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  we_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [2*DATA_W-1:0]   count_i,
    input  logic                  flag_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [2*DATA_W-1:0]   load_o,
    output ctrl_t                 ctrl_o,
    output logic                  clr_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] load_lo;
        logic [DATA_W-1:0] load_hi;
        ctrl_t             ctrl;
    } regs_t;

    regs_t             reg_d, reg_q;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        unused_addr_lsb;

    assign idx             = addr_i[ADDR_W-1:2];
    assign unused_addr_lsb = addr_i[1:0];

    always_comb begin
        reg_d = reg_q;
        clr_o = 1'b0;
        if (we_i) begin
            if (idx == IDX_W'(IDX_LOAD_LO)) reg_d.load_lo = wdata_i;
            if (idx == IDX_W'(IDX_LOAD_HI)) reg_d.load_hi = wdata_i;
            if (idx == IDX_W'(IDX_CTRL))    reg_d.ctrl    = ctrl_t'(wdata_i[2:0]);
            if (idx == IDX_W'(IDX_FLAG))    clr_o         = wdata_i[0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (idx == IDX_W'(IDX_LOAD_LO)) rdata_o = reg_q.load_lo;
        if (idx == IDX_W'(IDX_LOAD_HI)) rdata_o = reg_q.load_hi;
        if (idx == IDX_W'(IDX_CNT_LO))  rdata_o = count_i[DATA_W-1:0];
        if (idx == IDX_W'(IDX_CNT_HI))  rdata_o = count_i[CNT_W-1:DATA_W];
        if (idx == IDX_W'(IDX_CTRL))    rdata_o = DATA_W'(reg_q.ctrl);
        if (idx == IDX_W'(IDX_FLAG))    rdata_o = DATA_W'(flag_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign load_o = {reg_q.load_hi, reg_q.load_lo};
    assign ctrl_o = reg_q.ctrl;

    // R2: control word keeps what was written to it
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx == IDX_W'(IDX_CTRL)) |=> (ctrl_o == ctrl_t'($past(wdata_i[2:0]))));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run_prev;
        logic             parked;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic arm;
    logic at_zero;

    assign arm      = run_i & ~cnt_q.run_prev;
    assign at_zero  = (cnt_q.count == '0);
    assign expire_o = run_i & ~arm & at_zero & ~cnt_q.parked;

    always_comb begin
        cnt_d          = cnt_q;
        cnt_d.run_prev = run_i;
        if (arm) begin
            cnt_d.count  = load_i;
            cnt_d.parked = 1'b0;
        end else if (run_i && !cnt_q.parked) begin
            if (at_zero) begin
                if (oneshot_i) cnt_d.parked = 1'b1;
                else           cnt_d.count  = load_i;
            end else begin
                cnt_d.count = cnt_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q.count;

    // R3: a start of the run loads the whole start value
    assert_arm_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count_o == $past(load_i)));

    // R4: stopped counter holds its value
    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_o == $past(count_o)));

    // R5: free-running expiry reloads
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !oneshot_i) |=> (count_o == $past(load_i)));

    // R6: parked one-shot stays at zero without new expiries
    assert_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.parked && !arm) |=> (count_o == '0 && !expire_o));

endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic unmask_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (expire_i)   irq_d.flag = 1'b1;
        else if (clr_i) irq_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign flag_o = irq_q.flag;
    assign irq_o  = irq_q.flag & unmask_i;

    // R7: an expiry always leaves the flag set, even against a clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_o);

    // R7: a clear without expiry drops the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> !flag_o);

    // R7: flag is sticky without a clear
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/countdown_timer64.sv
module countdown_timer64
    import cdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count_val;
    ctrl_t            ctrl;
    logic             clr_pulse;
    logic             expire;
    logic             flag;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .we_i    (bus_we),
        .wdata_i (bus_wdata),
        .count_i (count_val),
        .flag_i  (flag),
        .rdata_o (bus_rdata),
        .load_o  (load_val),
        .ctrl_o  (ctrl),
        .clr_o   (clr_pulse)
    );

    cdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .oneshot_i (ctrl.oneshot),
        .load_i    (load_val),
        .count_o   (count_val),
        .expire_o  (expire)
    );

    cdt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (clr_pulse),
        .unmask_i (ctrl.unmask),
        .flag_o   (flag),
        .irq_o    (irq)
    );

    // R8: masked expiries still record the flag
    assert_masked_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl.unmask) |=> flag);

endmodule

// File: tb/countdown_timer64_test.sv
module countdown_timer64_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #10 clk = ~clk;

    countdown_timer64 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    typedef struct {
        logic        on_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    item_t       cur;
    logic        mon_req = 1'b0;
    logic [31:0] actual;
    int          n_checks = 0;
    int          n_fail = 0;

    localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_CLO = 5'h08,
                           A_CHI = 5'h0C, A_CTL = 5'h10, A_FLG = 5'h18;

    // Monitor: pops expected items and compares away from the rising edge
    always @(negedge clk) begin
        if (mon_req && sb.size() > 0) begin
            cur = sb.pop_front();
            actual = cur.on_irq ? {31'b0, irq} : rdata;
            n_checks++;
            if (actual !== cur.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", cur.tag, actual, cur.exp);
            end
        end
    end

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        addr = a; we = 1'b1; wdata = v;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic exp_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        addr = a;
        sb.push_back('{1'b0, e, tag});
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic exp_irq(input logic e, input string tag);
        @(posedge clk); #1;
        sb.push_back('{1'b1, {31'b0, e}, tag});
        mon_req = 1'b1;
        @(negedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        exp_rd(A_LLO, 32'h0, "R1 load low");
        exp_rd(A_LHI, 32'h0, "R1 load high");
        exp_rd(A_CLO, 32'h0, "R1 count low");
        exp_rd(A_CHI, 32'h0, "R1 count high");
        exp_rd(A_CTL, 32'h0, "R1 control");
        exp_rd(A_FLG, 32'h0, "R1 flag");
        exp_irq(1'b0, "R1 irq");

        // R6: one-shot, start value 5, unmasked; expiry on 7th edge after enable
        bus_wr(A_LLO, 32'd5);
        bus_wr(A_CTL, 32'b111);
        idle(5);
        exp_irq(1'b0, "R6 irq before expiry");
        exp_irq(1'b1, "R6 irq at expiry");
        exp_rd(A_CLO, 32'h0, "R6 count parked at zero");
        idle(10);
        exp_rd(A_CLO, 32'h0, "R6 count still zero");
        bus_wr(A_FLG, 32'h1);
        exp_rd(A_FLG, 32'h0, "R7 flag cleared");
        exp_irq(1'b0, "R8 irq follows cleared flag");
        idle(10);
        exp_rd(A_FLG, 32'h0, "R6 no second expiry");

        // R5: free-running, start value 3 -> period 4
        bus_wr(A_CTL, 32'b000);
        bus_wr(A_LLO, 32'd3);
        bus_wr(A_CTL, 32'b101);
        idle(3);
        exp_irq(1'b0, "R5 before first expiry");
        exp_irq(1'b1, "R5 first expiry");
        bus_wr(A_FLG, 32'h1);
        exp_irq(1'b0, "R5 cleared between expiries");
        exp_irq(1'b1, "R5 second expiry after L+1 cycles");
        exp_rd(A_CLO, 32'd2, "R5 reloaded and counting");

        // R8: masked expiry still sets flag; unmask raises irq
        bus_wr(A_CTL, 32'b000);
        bus_wr(A_FLG, 32'h1);
        bus_wr(A_CTL, 32'b001);
        idle(4);
        exp_rd(A_FLG, 32'h1, "R8 flag set while masked");
        exp_irq(1'b0, "R8 irq masked");
        bus_wr(A_CTL, 32'b101);
        exp_irq(1'b1, "R8 irq after unmask");

        // R4 / R3: stop holds count, restart reloads
        bus_wr(A_CTL, 32'b000);
        bus_wr(A_LLO, 32'd100);
        bus_wr(A_CTL, 32'b011);
        bus_wr(A_CTL, 32'b000);
        idle(5);
        exp_rd(A_CLO, 32'd99, "R4 count held while stopped");
        exp_rd(A_CHI, 32'd0, "R4 high word held");
        bus_wr(A_CNT_DUMMY(), 32'h55);
        exp_rd(A_CLO, 32'd99, "R2 write to count ignored");
        bus_wr(A_CTL, 32'b011);
        exp_rd(A_CLO, 32'd100, "R3 restart loads start value");

        // R4: borrow across words with live reads
        bus_wr(A_CTL, 32'b000);
        bus_wr(A_LLO, 32'd2);
        bus_wr(A_LHI, 32'd1);
        exp_rd(A_LHI, 32'd1, "R2 load high readback");
        bus_wr(A_CTL, 32'b001);
        exp_rd(A_CHI, 32'd1, "R3 high word after start");
        exp_rd(A_CLO, 32'd1, "R4 low word step");
        exp_rd(A_CLO, 32'd0, "R4 low word reaches zero");
        exp_rd(A_CHI, 32'd0, "R4 borrow into high word");
        exp_rd(A_CLO, 32'hFFFF_FFFE, "R4 low word wraps");
        exp_rd(A_CTL, 32'b001, "R2 control readback");

        // R7: clear collides with an expiry on every edge
        bus_wr(A_CTL, 32'b000);
        bus_wr(A_LLO, 32'd0);
        bus_wr(A_LHI, 32'd0);
        bus_wr(A_CTL, 32'b001);
        idle(3);
        bus_wr(A_FLG, 32'h1);
        exp_rd(A_FLG, 32'h1, "R7 expiry wins over clear");

        idle(2);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        finish_run();
    end

    function automatic logic [4:0] A_CNT_DUMMY();
        return A_CLO;
    endfunction

endmodule